// File: doc/BRIEF.md
# HDLC Status and Interrupt Register Bank

This block holds the status word that a host reads to follow an HDLC controller. One word mixes two kinds of bit. Sticky event bits capture single-cycle pulses from the receive and transmit paths. They hold their value until the host writes a one over them. Live condition bits show the present state of level signals and of a transmit FIFO fill comparison. They keep no history, and host writes do not change them.

Each sticky bit has its own interrupt enable. The active-low interrupt line goes low while any enabled sticky bit is set. It goes high again when the host has cleared every such bit or has disabled it. Live condition bits never pull the line. A programmable low mark is compared with the transmit FIFO fill level, and the result appears as one live bit.

The host side is a plain register port. A write takes effect on the clock edge. A read is a combinational select of the addressed word and has no side effects.

Top module: `hdlc_stat_regs`

## Requirements
- R1: A pulse on `evt_pulse[i]` sets sticky bit i, which reads as 1 in bits [N_EVT-1:0] of the status word (address 0) from the cycle after the pulse.
- R2: A set sticky bit stays set with no further pulse. A status write with 0 in its position leaves it unchanged.
- R3: A status write with 1 in a sticky bit's position clears it from the next cycle. The bit stays 0 until a new pulse arrives.
- R4: When a pulse and a write-one clear reach the same sticky bit in the same cycle, the bit ends up set.
- R5: Status bits [N_EVT+1 +: N_RT] follow `rt_cond` in the same cycle, and status writes do not affect them.
- R6: Status bit N_EVT is 1 exactly while `tx_level` is strictly less than the low mark held at address 2.
- R7: `irq_n` is 0 exactly while some sticky bit is set and its enable bit at address 1 is 1 (1 = enabled). Disabled sticky bits and live bits never drive it. Enabling a bit that is already set pulls `irq_n` low from the next cycle.
- R8: After reset the sticky bits, the enables and the low mark are all 0, so every event is masked and `irq_n` is 1.
- R9: The enable word (address 1, bits [N_EVT-1:0]) and the low mark (address 2, bits [LVL_W-1:0]) read back as written, with upper bits 0. Address 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | N_EVT | Event pulses that set sticky bits |
| rt_cond | input | N_RT | Live condition levels |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| host_cs | input | 1 | Host access select |
| host_wr | input | 1 | Host write strobe (with host_cs) |
| host_addr | input | 2 | Register address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data of the addressed register |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to bring about is a collision, where a pulse lands on a bit in the same cycle that the host writes a one to clear it. The ports allow it only when the event input and the write strobe are driven on the same edge. The stimulus table therefore holds rows that combine a pulse with a write. In one of those rows the clear also covers live bit positions, which shows that such writes are ignored. The directed tests then step the enable word over bits that are already latched, so that the interrupt must change with no new event.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  typedef enum logic [1:0] {
    RA_STATUS  = 2'd0,
    RA_IRQEN   = 2'd1,
    RA_LOWMARK = 2'd2,
    RA_SPARE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/hsr_latch_bank.sv
module hsr_latch_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  // The event term is ORed in last, so a pulse beats a clear in the same cycle.
  function automatic logic next_bit(input logic cur, input logic set, input logic wipe);
    return set | (cur & ~wipe);
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= next_bit(q[i], evt[i], clr[i]);
    end
  end
endmodule

// File: rtl/hsr_level_cmp.sv
module hsr_level_cmp #(
  parameter int LVL_W = 7
) (
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] mark,
  output logic             below
);
  function automatic logic is_below(input logic [LVL_W-1:0] l, input logic [LVL_W-1:0] m);
    return l < m;
  endfunction

  assign below = is_below(level, mark);
endmodule

// File: rtl/hsr_irq.sv
module hsr_irq #(
  parameter int N = 5
) (
  input  logic [N-1:0] lat,
  input  logic [N-1:0] en,
  output logic         irq_n
);
  function automatic logic any_live(input logic [N-1:0] a, input logic [N-1:0] b);
    return |(a & b);
  endfunction

  assign irq_n = ~any_live(lat, en);
endmodule

// File: rtl/hdlc_stat_regs.sv
module hdlc_stat_regs #(
  parameter int N_EVT  = 5,
  parameter int N_RT   = 2,
  parameter int LVL_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  evt_pulse,
  input  logic [N_RT-1:0]   rt_cond,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic              host_cs,
  input  logic              host_wr,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq_n
);
  import hsr_pkg::*;

  localparam int RT_LSB = N_EVT + 1;

  logic               wr_stb;
  logic [N_EVT-1:0]   clr_mask;
  logic [N_EVT-1:0]   lat_q;
  logic [N_EVT-1:0]   irq_en_q;
  logic [LVL_W-1:0]   low_mark_q;
  logic               tx_below;
  logic               unused_wdata;

  assign unused_wdata = ^host_wdata;
  assign wr_stb = host_cs & host_wr;

  // Write-one-to-clear mask for the sticky bits.
  assign clr_mask = (wr_stb && reg_addr_e'(host_addr) == RA_STATUS)
                    ? host_wdata[N_EVT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en_q   <= '0;
      low_mark_q <= '0;
    end else if (wr_stb) begin
      if (reg_addr_e'(host_addr) == RA_IRQEN)   irq_en_q   <= host_wdata[N_EVT-1:0];
      if (reg_addr_e'(host_addr) == RA_LOWMARK) low_mark_q <= host_wdata[LVL_W-1:0];
    end
  end

  hsr_latch_bank #(.N(N_EVT)) u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt_pulse),
    .clr   (clr_mask),
    .q     (lat_q)
  );

  hsr_level_cmp #(.LVL_W(LVL_W)) u_cmp (
    .level (tx_level),
    .mark  (low_mark_q),
    .below (tx_below)
  );

  hsr_irq #(.N(N_EVT)) u_irq (
    .lat   (lat_q),
    .en    (irq_en_q),
    .irq_n (irq_n)
  );

  always_comb begin
    host_rdata = '0;
    unique case (reg_addr_e'(host_addr))
      RA_STATUS: begin
        host_rdata[N_EVT-1:0]       = lat_q;
        host_rdata[N_EVT]           = tx_below;
        host_rdata[RT_LSB +: N_RT]  = rt_cond;
      end
      RA_IRQEN:   host_rdata[N_EVT-1:0] = irq_en_q;
      RA_LOWMARK: host_rdata[LVL_W-1:0] = low_mark_q;
      RA_SPARE:   host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/hsr_chk.sv
module hsr_chk #(
  parameter int N_EVT = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_EVT-1:0] evt_pulse,
  input logic [N_EVT-1:0] clr_mask,
  input logic [N_EVT-1:0] lat_q,
  input logic [N_EVT-1:0] irq_en_q,
  input logic             irq_n
);
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((lat_q & $past(evt_pulse)) == $past(evt_pulse))); // R1
  AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(lat_q) & ~$past(clr_mask) & ~lat_q) == '0)); // R2
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(clr_mask) & ~$past(evt_pulse) & lat_q) == '0)); // R3
  AST_NO_SPUR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((lat_q & ~$past(lat_q) & ~$past(evt_pulse)) == '0)); // R3
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> ((lat_q & irq_en_q) != '0)); // R7
  AST_IRQ_NOT_MISSED: assert property (@(posedge clk) disable iff (!rst_n)
    ((lat_q & irq_en_q) != '0) |-> !irq_n); // R7
endmodule

bind hdlc_stat_regs hsr_chk #(.N_EVT(N_EVT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_pulse (evt_pulse),
  .clr_mask  (clr_mask),
  .lat_q     (lat_q),
  .irq_en_q  (irq_en_q),
  .irq_n     (irq_n)
);

// File: tb/sim_hdlc_stat_regs.sv
`timescale 1ns/1ps
module sim_hdlc_stat_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] evt_pulse = '0;
  logic [1:0] rt_cond = '0;
  logic [6:0] tx_level = '0;
  logic       host_cs = 1'b0;
  logic       host_wr = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       irq_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hdlc_stat_regs u0 (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .rt_cond(rt_cond),
    .tx_level(tx_level), .host_cs(host_cs), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq_n(irq_n)
  );

  // {event, write, addr, wdata, expected sticky bits afterwards}
  localparam int NV = 8;
  localparam logic [20:0] VEC [NV] = '{
    {5'b00001, 1'b0, 2'd0, 8'h00, 5'b00001},  // R1
    {5'b00100, 1'b0, 2'd0, 8'h00, 5'b00101},  // R1
    {5'b00000, 1'b1, 2'd0, 8'h00, 5'b00101},  // R2
    {5'b00000, 1'b1, 2'd0, 8'h01, 5'b00100},  // R3
    {5'b00000, 1'b0, 2'd0, 8'h00, 5'b00100},  // R3
    {5'b00100, 1'b1, 2'd0, 8'h04, 5'b00100},  // R4
    {5'b11000, 1'b1, 2'd0, 8'hE4, 5'b11000},  // R4
    {5'b00000, 1'b1, 2'd0, 8'hFF, 5'b00000}   // R3
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic access(input logic [4:0] e, input logic w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    evt_pulse = e; host_cs = w; host_wr = w; host_addr = a; host_wdata = d;
    @(negedge clk);
    evt_pulse = '0; host_cs = 1'b0; host_wr = 1'b0; host_wdata = '0;
  endtask

  initial begin
    #150000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    rd(2'd0, d); check("R8 status", d, 8'h00);
    rd(2'd1, d); check("R8 enable", d, 8'h00);
    rd(2'd2, d); check("R8 lowmark", d, 8'h00);
    check("R8 irq_n", {7'd0, irq_n}, 8'h01);

    // stimulus table, all events masked
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][20:16], VEC[i][15], VEC[i][14:13], VEC[i][12:5]);
      rd(2'd0, d);
      check($sformatf("vec%0d sticky", i), {3'd0, d[4:0]}, {3'd0, VEC[i][4:0]});
      check($sformatf("vec%0d R7 masked irq", i), {7'd0, irq_n}, 8'h01);
    end

    // R9 readback
    access(5'd0, 1'b1, 2'd1, 8'hF2);
    rd(2'd1, d); check("R9 enable", d, 8'h12);
    access(5'd0, 1'b1, 2'd2, 8'h8A);
    rd(2'd2, d); check("R9 lowmark", d, 8'h0A);
    access(5'd0, 1'b1, 2'd3, 8'hFF);
    rd(2'd3, d); check("R9 spare", d, 8'h00);
    rd(2'd1, d); check("R9 spare write no effect", d, 8'h12);

    // R6 low-mark comparison (mark = 10)
    tx_level = 7'd9;  rd(2'd0, d); check("R6 below", {7'd0, d[5]}, 8'h01);
    tx_level = 7'd10; rd(2'd0, d); check("R6 equal", {7'd0, d[5]}, 8'h00);
    tx_level = 7'd11; rd(2'd0, d); check("R6 above", {7'd0, d[5]}, 8'h00);

    // R5 live bits follow and ignore writes
    rt_cond = 2'b10;
    rd(2'd0, d); check("R5 follow", {6'd0, d[7:6]}, 8'h02);
    access(5'd0, 1'b1, 2'd0, 8'hFF);
    rd(2'd0, d); check("R5 write ignored", d, 8'h80);
    rt_cond = 2'b01;
    rd(2'd0, d); check("R5 follow again", {6'd0, d[7:6]}, 8'h01);

    // R7 interrupt with enable = bits 1 and 4
    access(5'b00001, 1'b0, 2'd0, 8'h00);
    check("R7 disabled event", {7'd0, irq_n}, 8'h01);
    access(5'b00010, 1'b0, 2'd0, 8'h00);
    check("R7 enabled event", {7'd0, irq_n}, 8'h00);
    access(5'd0, 1'b1, 2'd0, 8'h02);
    check("R7 clear releases", {7'd0, irq_n}, 8'h01);
    access(5'd0, 1'b1, 2'd1, 8'h13);
    check("R7 enable pending", {7'd0, irq_n}, 8'h00);
    access(5'd0, 1'b1, 2'd0, 8'h01);
    check("R7 last cleared", {7'd0, irq_n}, 8'h01);
    access(5'd0, 1'b1, 2'd1, 8'h1F);
    rt_cond = 2'b11; tx_level = 7'd0;
    @(negedge clk);
    check("R7 live bits no irq", {7'd0, irq_n}, 8'h01);
    rd(2'd0, d); check("R2 sticky clear", {3'd0, d[4:0]}, 8'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule